// File: doc/BRIEF.md
# Stochastic Spike-Timing Binary Synapse Updater

This block is the learning engine for a crossbar of one-bit synapses that connects ROWS input neurons to COLS output neurons. It keeps a saturating age counter for every row (time since that input last fired) and for every column (time since that output last fired). Time advances in steps of the tick input. When an input neuron fires, every synapse on its row may be cleared (depression). When an output neuron fires, every synapse in its column may be set (potentiation). The potentiation pass starts only after a fixed number of ticks, so that inputs which fire inside that window count as anti-causal and not as causal.

For each synapse the block turns the spike-time gap into an index. It reads an 8-bit probability from a loadable table for that polarity and compares the value against the low byte of a 16-bit LFSR. If the random byte is lower, the synapse takes the target state. The synapse bits live in an external single-bit memory. The block visits one synapse per cycle through a read-modify-write port and writes only bits that actually change. Because the tables are loaded from outside, any decay profile can be used, including the exponential one.

Top module: `stdp_binary_updater`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, mem_en_o and mem_we_o are 0. Reset clears every probability entry to 0, sets every row and column age to its saturated value (never fired) and seeds the LFSR with 0xACE1.
- R2: With tbl_we_i high, tbl_data_i is stored at entry tbl_addr_i of the potentiation table when tbl_pol_i is 0, or of the depression table when tbl_pol_i is 1. An entry of 0 never switches a synapse.
- R3: An age counter becomes 0 in the cycle its neuron fires. It then rises by one in each cycle with tick_i high and stops at 2^AGE_W-1 without wrapping. A spike wins over a tick in the same cycle.
- R4: A spike on row r queues a depression pass over row r. The pass visits columns 0 to COLS-1 in that order, one per cycle, and the first visit is on the bus in the second cycle after the spike cycle. The gap for column c is the age of column c. A gap of 0 (both fired on the same tick) never switches. Otherwise the depression entry at gap-1 is used.
- R5: A spike on column c arms a delay of NEG_WIN ticks, and a new spike on c restarts it. On the NEG_WIN-th tick, a potentiation pass over column c is queued. It visits rows 0 to ROWS-1 in order, with gap = row age - NEG_WIN. A gap of 0 or less never switches. Otherwise the potentiation entry at gap-1 is used.
- R6: A gap larger than 2^IDX_W (64 by default) gives probability 0.
- R7: The random value is the low PROB_W bits of a 16-bit LFSR. Each step shifts the LFSR toward the MSB and feeds in bit15^bit13^bit12^bit10 as the new LSB. A synapse switches only when the random value is strictly below the table entry. The LFSR steps once for every visited synapse and holds otherwise.
- R8: Potentiation writes 1 and depression writes 0 on mem_wdata_o. mem_we_o is raised only when a switch is drawn and mem_rdata_i differs from the target.
- R9: Passes never overlap and touch one synapse per cycle. When a pass may start, queued depression passes (lowest row first) go before queued potentiation passes (lowest column first).
- R10: mem_addr_o = row*COLS + column. mem_rdata_i is used in the cycle mem_en_o is high, and a write takes effect at the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One time step for all age counters |
| pre_spk_i | input | ROWS | Input-neuron spikes, one bit per row |
| post_spk_i | input | COLS | Output-neuron spikes, one bit per column |
| tbl_we_i | input | 1 | Probability table write strobe |
| tbl_pol_i | input | 1 | Table select: 0 potentiation, 1 depression |
| tbl_addr_i | input | IDX_W | Table entry index |
| tbl_data_i | input | PROB_W | Probability fraction to store |
| mem_en_o | output | 1 | Synapse visit this cycle |
| mem_addr_o | output | ADDR_W | Synapse address, row*COLS+column |
| mem_rdata_i | input | 1 | Current bit of the visited synapse |
| mem_we_o | output | 1 | Write the visited synapse |
| mem_wdata_o | output | 1 | New synapse value |

## Verification
A spike is registered at the first clock edge. The pass starts at the next edge, so the first visit is on the bus in the second cycle after the spike cycle, and a pass ends ROWS or COLS cycles later. The timing checks sample on the falling edge in exactly those cycles. A potentiation pass appears only after the NEG_WIN-th tick; the bench confirms that the bus stays silent after NEG_WIN-1 ticks. Result checks on the synapse memory are made only after a quiet period longer than the longest chain of queued passes, and no ticks are sent during a pass. In this way the ages used by the bench's own model equal those seen by the design.

// File: rtl/stdp_pkg.sv
package stdp_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_DEP  = 2'd1,
    SQ_POT  = 2'd2
  } seq_e;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;

  // one shift of the 16-bit generator, taps 16,14,13,11
  function automatic logic [15:0] lfsr_advance(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // spike-time gap in ticks; 0 means no causal/anti-causal pair
  function automatic int unsigned spike_gap(input logic is_pot,
                                            input int unsigned age,
                                            input int unsigned neg_win);
    if (!is_pot) return age;
    if (age > neg_win) return age - neg_win;
    return 0;
  endfunction

endpackage

// File: rtl/stdp_age_bank.sv
module stdp_age_bank #(
  parameter int N     = 4,
  parameter int AGE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_i,
  input  logic [N-1:0]              spike_i,
  output logic [N-1:0][AGE_W-1:0]   age_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  for (genvar g = 0; g < N; g++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (!rst_n)                          age_o[g] <= AGE_MAX;
      else if (spike_i[g])                 age_o[g] <= '0;
      else if (tick_i && age_o[g] != AGE_MAX) age_o[g] <= age_o[g] + 1'b1;
    end
  end
endmodule

// File: rtl/stdp_post_delay.sv
module stdp_post_delay #(
  parameter int N       = 4,
  parameter int NEG_WIN = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [N-1:0] spike_i,
  output logic [N-1:0] fire_o
);
  localparam int CNT_W = $clog2(NEG_WIN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NEG_WIN - 1);

  for (genvar g = 0; g < N; g++) begin : g_dly
    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        armed_q   <= 1'b0;
        cnt_q     <= '0;
        fire_o[g] <= 1'b0;
      end else begin
        fire_o[g] <= 1'b0;
        if (spike_i[g]) begin
          armed_q <= 1'b1;
          cnt_q   <= '0;
        end else if (tick_i && armed_q) begin
          if (cnt_q == CNT_LAST) begin
            armed_q   <= 1'b0;
            fire_o[g] <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/stdp_prob_table.sv
module stdp_prob_table #(
  parameter int IDX_W  = 6,
  parameter int PROB_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [PROB_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [PROB_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;
  logic [PROB_W-1:0] ent_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (we_i) begin
      ent_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = ent_q[raddr_i];
endmodule

// File: rtl/stdp_lfsr.sv
module stdp_lfsr #(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  output logic [OUT_W-1:0] rand_o
);
  import stdp_pkg::*;
  logic [15:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      state_q <= LFSR_SEED;
    else if (step_i) state_q <= lfsr_advance(state_q);
  end

  assign rand_o = state_q[OUT_W-1:0];
endmodule

// File: rtl/stdp_binary_updater.sv
module stdp_binary_updater #(
  parameter int ROWS    = 4,
  parameter int COLS    = 4,
  parameter int AGE_W   = 8,
  parameter int IDX_W   = 6,
  parameter int PROB_W  = 8,
  parameter int NEG_WIN = 4,
  localparam int ADDR_W = (ROWS * COLS > 1) ? $clog2(ROWS * COLS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [ROWS-1:0]   pre_spk_i,
  input  logic [COLS-1:0]   post_spk_i,
  input  logic              tbl_we_i,
  input  logic              tbl_pol_i,
  input  logic [IDX_W-1:0]  tbl_addr_i,
  input  logic [PROB_W-1:0] tbl_data_i,
  output logic              mem_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rdata_i,
  output logic              mem_we_o,
  output logic              mem_wdata_o
);
  import stdp_pkg::*;

  localparam int DEPTH = 1 << IDX_W;
  localparam int MAXD  = (ROWS > COLS) ? ROWS : COLS;
  localparam int POS_W = (MAXD > 1) ? $clog2(MAXD) : 1;
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;

  // timing state
  logic [ROWS-1:0][AGE_W-1:0] pre_age;
  logic [COLS-1:0][AGE_W-1:0] post_age;
  logic [COLS-1:0]            pot_fire;

  stdp_age_bank #(.N(ROWS), .AGE_W(AGE_W)) u_pre_age (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .spike_i(pre_spk_i), .age_o(pre_age));

  stdp_age_bank #(.N(COLS), .AGE_W(AGE_W)) u_post_age (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .spike_i(post_spk_i), .age_o(post_age));

  stdp_post_delay #(.N(COLS), .NEG_WIN(NEG_WIN)) u_delay (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .spike_i(post_spk_i), .fire_o(pot_fire));

  // sequencer state
  seq_e              state_q;
  logic [POS_W-1:0]  line_q, pos_q;
  logic [ROWS-1:0]   dep_req_q, dep_req_d;
  logic [COLS-1:0]   pot_req_q, pot_req_d;
  logic [POS_W-1:0]  dep_pick, pot_pick;

  // named internal events for the checker
  logic              visit_w, is_pot_w, idx_ok_w, hit_w;
  logic [PROB_W-1:0] prob_w, rand_w;
  int unsigned       gap_w;

  logic [ROW_W-1:0]  row_sel;
  logic [COL_W-1:0]  col_sel;
  logic [AGE_W-1:0]  age_sel;
  logic [IDX_W-1:0]  tbl_idx;
  logic [1:0][PROB_W-1:0] tbl_rd;
  int                last_pos;

  always_comb begin
    dep_pick = '0;
    for (int i = ROWS - 1; i >= 0; i--) if (dep_req_q[i]) dep_pick = POS_W'(i);
    pot_pick = '0;
    for (int i = COLS - 1; i >= 0; i--) if (pot_req_q[i]) pot_pick = POS_W'(i);
  end

  always_comb begin
    dep_req_d = dep_req_q;
    pot_req_d = pot_req_q;
    if (state_q == SQ_IDLE) begin
      if (|dep_req_q)      dep_req_d[dep_pick] = 1'b0;
      else if (|pot_req_q) pot_req_d[pot_pick] = 1'b0;
    end
    dep_req_d = dep_req_d | pre_spk_i;
    pot_req_d = pot_req_d | pot_fire;
  end

  assign visit_w  = (state_q != SQ_IDLE);
  assign is_pot_w = (state_q == SQ_POT);
  assign last_pos = is_pot_w ? ROWS - 1 : COLS - 1;

  always_comb begin
    row_sel = is_pot_w ? ROW_W'(pos_q) : ROW_W'(line_q);
    col_sel = is_pot_w ? COL_W'(line_q) : COL_W'(pos_q);
    age_sel = is_pot_w ? pre_age[row_sel] : post_age[col_sel];
    gap_w   = spike_gap(is_pot_w, int'(age_sel), NEG_WIN);
    tbl_idx = IDX_W'(gap_w - 1);
  end

  // probability tables: index 0 potentiation, 1 depression
  for (genvar p = 0; p < 2; p++) begin : g_tbl
    stdp_prob_table #(.IDX_W(IDX_W), .PROB_W(PROB_W)) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .we_i(tbl_we_i && (tbl_pol_i == 1'(p))),
      .waddr_i(tbl_addr_i), .wdata_i(tbl_data_i),
      .raddr_i(tbl_idx), .rdata_o(tbl_rd[p]));
  end

  stdp_lfsr #(.OUT_W(PROB_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step_i(visit_w), .rand_o(rand_w));

  assign idx_ok_w = visit_w && (gap_w != 0) && (gap_w <= DEPTH);
  assign prob_w   = is_pot_w ? tbl_rd[0] : tbl_rd[1];
  assign hit_w    = idx_ok_w && (rand_w < prob_w);

  assign mem_en_o    = visit_w;
  assign mem_addr_o  = ADDR_W'(int'(row_sel) * COLS + int'(col_sel));
  assign mem_wdata_o = is_pot_w;
  assign mem_we_o    = hit_w && (mem_rdata_i != is_pot_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      line_q    <= '0;
      pos_q     <= '0;
      dep_req_q <= '0;
      pot_req_q <= '0;
    end else begin
      dep_req_q <= dep_req_d;
      pot_req_q <= pot_req_d;
      case (state_q)
        SQ_IDLE: begin
          pos_q <= '0;
          if (|dep_req_q) begin
            state_q <= SQ_DEP;
            line_q  <= dep_pick;
          end else if (|pot_req_q) begin
            state_q <= SQ_POT;
            line_q  <= pot_pick;
          end
        end
        default: begin
          if (pos_q == POS_W'(last_pos)) state_q <= SQ_IDLE;
          else                           pos_q   <= pos_q + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/stdp_updater_chk.sv
module stdp_updater_chk #(
  parameter int PROB_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic              mem_wdata_o,
  input logic              mem_rdata_i,
  input logic              is_pot_w,
  input logic              idx_ok_w,
  input logic              hit_w,
  input logic [PROB_W-1:0] prob_w,
  input logic [PROB_W-1:0] rand_w
);
  // R8
  write_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_wdata_o == is_pot_w));

  // R8
  no_redundant_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_wdata_o != mem_rdata_i));

  // R10
  write_in_visit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_en_o);

  // R6
  range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_ok_w |-> !hit_w);

  // R2
  zero_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prob_w == '0) |-> !hit_w);

  // R7
  rand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en_o |=> $stable(rand_w));
endmodule

bind stdp_binary_updater stdp_updater_chk #(.PROB_W(PROB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_en_o(mem_en_o), .mem_we_o(mem_we_o),
  .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .is_pot_w(is_pot_w),
  .idx_ok_w(idx_ok_w), .hit_w(hit_w), .prob_w(prob_w), .rand_w(rand_w));

// File: tb/sim_stdp_binary_updater.sv
module sim_stdp_binary_updater;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 4, COLS = 4, NSYN = 16, NEG_WIN = 4;
  localparam int AGE_MAX = 255, DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [ROWS-1:0] pre_spk = '0;
  logic [COLS-1:0] post_spk = '0;
  logic tbl_we = 1'b0, tbl_pol = 1'b0;
  logic [5:0] tbl_addr = '0;
  logic [7:0] tbl_data = '0;
  logic mem_en, mem_rdata, mem_we, mem_wdata;
  logic [3:0] mem_addr;

  logic bmem [NSYN];
  logic exp_mem [NSYN];
  int n_chk = 0, n_bad = 0;
  int wr_cnt = 0, vis_cnt = 0, log_n = 0;
  int vis_log [64];

  // bench-side model state
  logic [15:0] m_lfsr;
  int m_pot [DEPTH];
  int m_dep [DEPTH];
  int pre_t [ROWS];
  int post_t [COLS];
  int arm [COLS];
  int now_t;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stdp_binary_updater u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .pre_spk_i(pre_spk), .post_spk_i(post_spk),
    .tbl_we_i(tbl_we), .tbl_pol_i(tbl_pol), .tbl_addr_i(tbl_addr), .tbl_data_i(tbl_data),
    .mem_en_o(mem_en), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata));

  assign mem_rdata = bmem[mem_addr];

  always @(posedge clk) if (mem_we) begin
    bmem[mem_addr] <= mem_wdata;
    wr_cnt <= wr_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && mem_en) begin
    vis_cnt++;
    if (log_n < 64) vis_log[log_n] = int'(mem_addr);
    log_n++;
    if (mem_we && mem_wdata == bmem[mem_addr])
      check(1'b0, "R8", "redundant write", int'(mem_wdata), int'(!mem_wdata));
  end

  function automatic int age_of(input int t);
    if (t < 0) return AGE_MAX;
    return (now_t - t > AGE_MAX) ? AGE_MAX : now_t - t;
  endfunction

  task automatic model_visit(input bit pot, input int gap, input int addr);
    int p = 0;
    if (gap >= 1 && gap <= DEPTH) p = pot ? m_pot[gap - 1] : m_dep[gap - 1];
    if (int'(m_lfsr[7:0]) < p) exp_mem[addr] = pot;
    m_lfsr = {m_lfsr[14:0], ^(m_lfsr & 16'hB400)};
  endtask

  task automatic model_dep(input int r);
    for (int c = 0; c < COLS; c++) model_visit(1'b0, age_of(post_t[c]), r * COLS + c);
  endtask

  task automatic model_pot(input int c);
    for (int r = 0; r < ROWS; r++) begin
      int a = age_of(pre_t[r]);
      model_visit(1'b1, (a > NEG_WIN) ? a - NEG_WIN : 0, r * COLS + c);
    end
  endtask

  task automatic wait_quiet();
    repeat (30) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 0; pre_spk = '0; post_spk = '0; tbl_we = 0;
    repeat (3) @(negedge clk);
    m_lfsr = 16'hACE1; now_t = 0;
    for (int i = 0; i < DEPTH; i++) begin m_pot[i] = 0; m_dep[i] = 0; end
    for (int i = 0; i < ROWS; i++) pre_t[i] = -1;
    for (int i = 0; i < COLS; i++) begin post_t[i] = -1; arm[i] = 0; end
    // R1
    check(mem_en == 1'b0 && mem_we == 1'b0, "R1", "bus idle in reset", int'(mem_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_en == 1'b0 && mem_we == 1'b0, "R1", "bus idle after reset", int'(mem_en), 0);
  endtask

  task automatic load(input bit pol, input int addr, input int val);
    @(negedge clk);
    tbl_we = 1; tbl_pol = pol; tbl_addr = 6'(addr); tbl_data = 8'(val);
    @(negedge clk);
    tbl_we = 0;
    if (pol) m_dep[addr] = val; else m_pot[addr] = val;
  endtask

  task automatic set_syn(input int addr, input bit v);
    bmem[addr] = v; exp_mem[addr] = v;
  endtask

  task automatic spikes(input logic [ROWS-1:0] pm, input logic [COLS-1:0] qm);
    @(negedge clk);
    pre_spk = pm; post_spk = qm;
    @(negedge clk);
    pre_spk = '0; post_spk = '0;
    for (int c = 0; c < COLS; c++) if (qm[c]) begin post_t[c] = now_t; arm[c] = NEG_WIN; end
    for (int r = 0; r < ROWS; r++) if (pm[r]) pre_t[r] = now_t;
    for (int r = 0; r < ROWS; r++) if (pm[r]) model_dep(r);
    wait_quiet();
  endtask

  task automatic tick_pre(input logic [ROWS-1:0] pm);
    bit fired = 0;
    @(negedge clk);
    tick = 1; pre_spk = pm;
    @(negedge clk);
    tick = 0; pre_spk = '0;
    now_t++;
    for (int r = 0; r < ROWS; r++) if (pm[r]) pre_t[r] = now_t;
    for (int r = 0; r < ROWS; r++) if (pm[r]) model_dep(r);
    for (int c = 0; c < COLS; c++) if (arm[c] > 0) begin
      arm[c]--;
      if (arm[c] == 0) begin model_pot(c); fired = 1; end
    end
    if (fired || pm != 0) wait_quiet();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick_pre('0);
  endtask

  task automatic compare_mem(input string req);
    for (int i = 0; i < NSYN; i++)
      check(bmem[i] === exp_mem[i], req, $sformatf("synapse %0d", i), int'(bmem[i]), int'(exp_mem[i]));
  endtask

  // R1 R4 R10: idle after reset, pass timing, address map, zero tables
  task automatic t_reset_and_timing();
    int w0, v0;
    do_reset();
    for (int i = 0; i < NSYN; i++) set_syn(i, (i % 3) != 2);
    w0 = wr_cnt; v0 = vis_cnt;
    @(negedge clk);
    pre_spk = 4'b0010;
    @(negedge clk);
    pre_spk = '0; pre_t[1] = now_t;
    check(mem_en == 1'b0, "R4", "no visit one cycle after spike", int'(mem_en), 0);
    @(negedge clk);
    check(mem_en == 1'b1, "R4", "visit two cycles after spike", int'(mem_en), 1);
    check(mem_addr == 4'd4, "R10", "first address row1 col0", int'(mem_addr), 4);
    model_dep(1);
    wait_quiet();
    check(vis_cnt - v0 == COLS, "R4", "depression pass length", vis_cnt - v0, COLS);
    check(wr_cnt == w0, "R2", "zero tables never write", wr_cnt - w0, 0);
    compare_mem("R2");
  endtask

  // R4 R2: depression through a loaded entry
  task automatic t_depress();
    load(1'b1, 2, 255);
    spikes('0, 4'b0010);
    ticks(3);
    spikes(4'b0100, '0);
    ticks(1);
    compare_mem("R4");
  endtask

  // R5: delayed potentiation pass
  task automatic t_potentiate();
    int v0;
    for (int i = 0; i < 8; i++) load(1'b0, i, 8'hC0);
    spikes(4'b1011, '0);
    ticks(2);
    spikes('0, 4'b0100);
    v0 = vis_cnt;
    ticks(NEG_WIN - 1);
    check(vis_cnt == v0, "R5", "no pass before delay ends", vis_cnt - v0, 0);
    ticks(1);
    check(vis_cnt - v0 == ROWS, "R5", "potentiation pass length", vis_cnt - v0, ROWS);
    compare_mem("R5");
  endtask

  // R4 R5: zero gap never switches
  task automatic t_zero_gap();
    load(1'b0, 0, 255);
    load(1'b1, 0, 255);
    set_syn(0, 1'b1);
    spikes(4'b0001, 4'b0001);
    check(bmem[0] == 1'b1, "R4", "same-tick pair not depressed", int'(bmem[0]), 1);
    set_syn(0, 1'b0);
    ticks(NEG_WIN);
    check(bmem[0] == 1'b0, "R5", "same-tick pair not potentiated", int'(bmem[0]), 0);
    compare_mem("R5");
  endtask

  // R6: gap past the table gives zero probability
  task automatic t_range();
    load(1'b1, 63, 255);
    spikes('0, 4'b1000);
    ticks(65);
    set_syn(7, 1'b1);
    spikes(4'b0010, '0);
    check(bmem[7] == 1'b1, "R6", "gap 65 ignored", int'(bmem[7]), 1);
    compare_mem("R6");
  endtask

  // R3: ages saturate instead of wrapping
  task automatic t_saturate();
    load(1'b1, 43, 255);
    spikes('0, 4'b0001);
    ticks(300);
    set_syn(8, 1'b1);
    spikes(4'b0100, '0);
    check(bmem[8] == 1'b1, "R3", "saturated age out of range", int'(bmem[8]), 1);
    compare_mem("R3");
  endtask

  // R9: service order
  task automatic t_order();
    log_n = 0;
    spikes(4'b1001, '0);
    check(vis_log[0] == 0, "R9", "row0 served first", vis_log[0], 0);
    check(vis_log[4] == 12, "R9", "row3 served second", vis_log[4], 12);
    spikes('0, 4'b0010);
    ticks(NEG_WIN - 1);
    log_n = 0;
    tick_pre(4'b0100);
    check(vis_log[0] == 8, "R9", "depression before potentiation", vis_log[0], 8);
    check(vis_log[4] == 1, "R9", "potentiation column1 after", vis_log[4], 1);
    check(vis_log[5] == 5, "R10", "row1 col1 address", vis_log[5], 5);
    compare_mem("R9");
  endtask

  // R8: synapse already at target gets no write
  task automatic t_no_write();
    int w0, v0;
    for (int i = 0; i < NSYN; i++) set_syn(i, 1'b0);
    for (int i = 0; i < 4; i++) load(1'b1, i, 255);
    spikes('0, 4'b1111);
    ticks(1);
    w0 = wr_cnt; v0 = vis_cnt;
    spikes(4'b0010, '0);
    check(vis_cnt - v0 == COLS, "R8", "cleared row still visited", vis_cnt - v0, COLS);
    check(wr_cnt == w0, "R8", "no write to cleared synapses", wr_cnt - w0, 0);
    ticks(NEG_WIN - 1);
    compare_mem("R8");
  endtask

  // R7: first random byte after reset is the seed low byte, strict compare
  task automatic t_lfsr(input int entry, input bit expv);
    do_reset();
    set_syn(0, 1'b1);
    load(1'b1, 0, entry);
    spikes('0, 4'b0001);
    ticks(1);
    spikes(4'b0001, '0);
    check(bmem[0] == expv, "R7", $sformatf("entry %0d vs rand 225", entry), int'(bmem[0]), int'(expv));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    t_reset_and_timing();
    t_depress();
    t_potentiate();
    t_zero_gap();
    t_range();
    t_saturate();
    t_order();
    t_no_write();
    t_lfsr(8'hE1, 1'b1);
    t_lfsr(8'hE2, 1'b0);
    finish_run();
  end
endmodule